// File: doc/BRIEF.md
# DMA Page Register Address Extender

This block holds sixteen 8-bit page registers that software writes and reads through an index port. Two DMA controllers sit beside it. The byte controller produces 16-bit byte offsets. The word controller produces 16-bit word offsets. The block does not model the controllers themselves.

When a controller acknowledges a transfer, it hands over:
- its identity,
- a channel number,
- an acknowledge kind,
- a 16-bit offset,
- a terminal count flag.

One cycle later the block presents a 24-bit physical address. The address is built from the page register tied to that controller and channel, together with the offset. The block also presents a size flag and the forwarded channel, kind and terminal count.

Channels map to page registers through a fixed, non-linear table. Each controller has its own half of the register file. The word controller's offset is doubled before the page is merged in. Verify acknowledges move no data, so they carry no address. Only their channel and terminal count pass through.

Top module: `dma_page_extender`

## Requirements
- R1: After reset every page register reads back as 0x00 and `xferValid` is low.
- R2: A write with `regWrEn` high stores `regWrData` into register `regIdx` at the clock edge. `regRdData` always shows the register selected by `regIdx`.
- R3: For controller 0 (`ackCtrl`=0), the channel selects a page register as follows: channel 0 uses register 7, channel 1 uses 3, channel 2 uses 1 and channel 3 uses 2.
- R4: For controller 1 (`ackCtrl`=1), the channel selects a page register as follows: channel 0 uses register 15, channel 1 uses 11, channel 2 uses 9 and channel 3 uses 10.
- R5: A non-verify acknowledge from controller 0 gives `xferAddr` = page<<16 OR offset, with `xferWord`=0.
- R6: A non-verify acknowledge from controller 1 gives `xferAddr` = (page<<16) OR (offset<<1), with `xferWord`=1. Bit 0 is therefore zero, and offset bit 15 is ORed into address bit 16.
- R7: An acknowledge whose `ackKind` has bit 1 set (codes 2 and 3 mean verify) gives `xferAddrValid`=0 and `xferAddr`=0. Channel and terminal count are still forwarded.
- R8: Each acknowledge cycle produces exactly one `xferValid` pulse in the next cycle. That pulse carries the acknowledge's channel, kind and terminal count unchanged. Non-verify kinds (codes 0 and 1) set `xferAddrValid`=1.
- R9: When a register write and an acknowledge that uses the same register occur in the same cycle, the address is formed from the page value held before the write.
- R10: Writes to registers 0, 4, 5, 6, 8, 12, 13 and 14 are stored and can be read back, but they never change any acknowledge's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Page register write strobe |
| regIdx | input | 4 | Page register index for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Contents of register `regIdx` |
| ackValid | input | 1 | Acknowledge present this cycle |
| ackCtrl | input | 1 | 0 = byte controller, 1 = word controller |
| ackChan | input | 2 | Channel 0..3 |
| ackKind | input | 2 | 0 = to memory, 1 = from memory, 2/3 = verify |
| ackOffset | input | 16 | Controller offset |
| ackTc | input | 1 | Terminal count flag |
| xferValid | output | 1 | Result pulse, one cycle after the acknowledge |
| xferAddrValid | output | 1 | Address is meaningful (non-verify) |
| xferAddr | output | 24 | Physical address |
| xferWord | output | 1 | 1 = word transfer, 0 = byte transfer |
| xferChan | output | 2 | Forwarded channel |
| xferKind | output | 2 | Forwarded kind |
| xferTc | output | 1 | Forwarded terminal count |

## Verification
Every register gets a distinct value before any acknowledge is made. Each of the eight controller/channel pairs then yields a page that identifies exactly one register, so any error in the channel map shows up as a wrong high byte.

The byte controller is driven with arbitrary offsets, which separates pass-through from shifting. The word controller is driven with offsets that have bit 15 set and pages that are even, which exposes whether the shifted-out bit is merged into the page field.

Verify acknowledges with both terminal count values show whether the address is suppressed while the side information still flows. A write that lands in the same cycle as an acknowledge on the same register tells pre-write sampling apart from post-write sampling. Writes to unmapped registers followed by a sweep over all channels confirm that those registers stay isolated.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  parameter int PAGE_W   = 8;
  parameter int OFF_W    = 16;
  parameter int PAGE_CNT = 16;
  parameter int CHAN_W   = 2;
  localparam int IDX_W   = $clog2(PAGE_CNT);
  localparam int ADDR_W  = PAGE_W + OFF_W;

  typedef struct packed {
    logic             pageWr;
    logic [IDX_W-1:0] wrIdx;
    logic             ackLoad;
    logic [IDX_W-1:0] ackIdx;
    logic             isWord;
    logic             makeAddr;
  } ctrlStrobes_t;
endpackage

// File: rtl/dpx_ctrl.sv
module dpx_ctrl
  import dpx_pkg::*;
(
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              ackValid,
  input  logic              ackCtrl,
  input  logic [CHAN_W-1:0] ackChan,
  input  logic [1:0]        ackKind,
  output ctrlStrobes_t      strb
);
  localparam int HALF_W = IDX_W - 1;

  logic [HALF_W-1:0] chanSlot;

  // Fixed, scrambled channel-to-slot map shared by both controllers
  always_comb begin
    unique case (ackChan)
      2'd0:    chanSlot = HALF_W'(7);
      2'd1:    chanSlot = HALF_W'(3);
      2'd2:    chanSlot = HALF_W'(1);
      default: chanSlot = HALF_W'(2);
    endcase
  end

  always_comb begin
    strb.pageWr   = regWrEn;
    strb.wrIdx    = regIdx;
    strb.ackLoad  = ackValid;
    strb.ackIdx   = {ackCtrl, chanSlot};
    strb.isWord   = ackCtrl;
    strb.makeAddr = ~ackKind[1];
  end
endmodule

// File: rtl/dpx_datapath.sv
module dpx_datapath
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [PAGE_W-1:0] regWrData,
  output logic [PAGE_W-1:0] regRdData,
  input  logic [CHAN_W-1:0] ackChan,
  input  logic [1:0]        ackKind,
  input  logic [OFF_W-1:0]  ackOffset,
  input  logic              ackTc,
  output logic              xferValid,
  output logic              xferAddrValid,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferWord,
  output logic [CHAN_W-1:0] xferChan,
  output logic [1:0]        xferKind,
  output logic              xferTc
);
  logic [PAGE_W-1:0] pageQ [PAGE_CNT];

  for (genvar g = 0; g < PAGE_CNT; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rstN)
        pageQ[g] <= '0;
      else if (strb.pageWr && strb.wrIdx == IDX_W'(g))
        pageQ[g] <= regWrData;
    end
  end

  assign regRdData = pageQ[regIdx];

  logic [PAGE_W-1:0] ackPage;
  logic [ADDR_W-1:0] pageField;
  logic [ADDR_W-1:0] offField;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    ackPage   = pageQ[strb.ackIdx];
    pageField = {ackPage, {OFF_W{1'b0}}};
    if (strb.isWord)
      offField = {{(PAGE_W-1){1'b0}}, ackOffset, 1'b0};
    else
      offField = {{PAGE_W{1'b0}}, ackOffset};
    addrNext = strb.makeAddr ? (pageField | offField) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferValid     <= 1'b0;
      xferAddrValid <= 1'b0;
      xferAddr      <= '0;
      xferWord      <= 1'b0;
      xferChan      <= '0;
      xferKind      <= '0;
      xferTc        <= 1'b0;
    end else begin
      xferValid <= strb.ackLoad;
      if (strb.ackLoad) begin
        xferAddrValid <= strb.makeAddr;
        xferAddr      <= addrNext;
        xferWord      <= strb.isWord;
        xferChan      <= ackChan;
        xferKind      <= ackKind;
        xferTc        <= ackTc;
      end
    end
  end
endmodule

// File: rtl/dma_page_extender.sv
module dma_page_extender
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [PAGE_W-1:0] regWrData,
  output logic [PAGE_W-1:0] regRdData,
  input  logic              ackValid,
  input  logic              ackCtrl,
  input  logic [CHAN_W-1:0] ackChan,
  input  logic [1:0]        ackKind,
  input  logic [OFF_W-1:0]  ackOffset,
  input  logic              ackTc,
  output logic              xferValid,
  output logic              xferAddrValid,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferWord,
  output logic [CHAN_W-1:0] xferChan,
  output logic [1:0]        xferKind,
  output logic              xferTc
);
  ctrlStrobes_t strb;

  dpx_ctrl ctrl_i (
    .regWrEn  (regWrEn),
    .regIdx   (regIdx),
    .ackValid (ackValid),
    .ackCtrl  (ackCtrl),
    .ackChan  (ackChan),
    .ackKind  (ackKind),
    .strb     (strb)
  );

  dpx_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .regIdx        (regIdx),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .ackChan       (ackChan),
    .ackKind       (ackKind),
    .ackOffset     (ackOffset),
    .ackTc         (ackTc),
    .xferValid     (xferValid),
    .xferAddrValid (xferAddrValid),
    .xferAddr      (xferAddr),
    .xferWord      (xferWord),
    .xferChan      (xferChan),
    .xferKind      (xferKind),
    .xferTc        (xferTc)
  );
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker
  import dpx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ackValid,
  input logic              ackCtrl,
  input logic [CHAN_W-1:0] ackChan,
  input logic [1:0]        ackKind,
  input logic [OFF_W-1:0]  ackOffset,
  input logic              ackTc,
  input logic              xferValid,
  input logic              xferAddrValid,
  input logic [ADDR_W-1:0] xferAddr,
  input logic              xferWord,
  input logic [CHAN_W-1:0] xferChan,
  input logic              xferTc
);
  AST_PULSE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> xferValid); // R8
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> !xferValid); // R8
  AST_SIDEBAND_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> (xferTc == $past(ackTc) && xferChan == $past(ackChan))); // R8
  AST_BYTE_LOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackCtrl && !ackKind[1]) |=>
      (!xferWord && xferAddr[OFF_W-1:0] == $past(ackOffset))); // R5
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferWord && xferAddrValid) |-> !xferAddr[0]); // R6
  AST_VERIFY_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackKind[1]) |=> (!xferAddrValid && xferAddr == '0)); // R7
endmodule

bind dma_page_extender dpx_checker chk_i (.*);

// File: tb/dma_page_extender_tb_top.sv
module dma_page_extender_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        ackValid = 1'b0;
  logic        ackCtrl = 1'b0;
  logic [1:0]  ackChan = '0;
  logic [1:0]  ackKind = '0;
  logic [15:0] ackOffset = '0;
  logic        ackTc = 1'b0;
  logic        xferValid, xferAddrValid, xferWord, xferTc;
  logic [23:0] xferAddr;
  logic [1:0]  xferChan, xferKind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  dma_page_extender dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int mapIdx(input bit ctrl, input int chan);
    int t[4] = '{7, 3, 1, 2};
    return t[chan] + (ctrl ? 8 : 0);
  endfunction

  function automatic logic [23:0] expAddr(input bit ctrl, input int chan, input logic [15:0] off);
    logic [23:0] p;
    p = {model[mapIdx(ctrl, chan)], 16'h0};
    return ctrl ? (p | {7'h0, off, 1'b0}) : (p | {8'h0, off});
  endfunction

  task automatic doWrite(input int idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = 4'(idx); regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    model[idx] = val;
  endtask

  task automatic readChk(input int idx, input string req);
    @(negedge clk);
    regIdx = 4'(idx);
    #1;
    chk(regRdData == model[idx], req, 32'(regRdData), 32'(model[idx]));
  endtask

  task automatic doAck(input bit ctrl, input int chan, input logic [1:0] kind,
                       input logic [15:0] off, input bit tc, input string req);
    logic [23:0] e;
    bit ver;
    ver = kind[1];
    e = ver ? 24'h0 : expAddr(ctrl, chan, off);
    @(negedge clk);
    ackValid = 1'b1; ackCtrl = ctrl; ackChan = 2'(chan); ackKind = kind;
    ackOffset = off; ackTc = tc;
    @(negedge clk);
    ackValid = 1'b0;
    chk(xferValid == 1'b1, req, 32'(xferValid), 1);
    chk(xferAddr == e, req, 32'(xferAddr), 32'(e));
    chk(xferAddrValid == !ver, req, 32'(xferAddrValid), 32'(!ver));
    chk(xferChan == 2'(chan) && xferTc == tc && xferKind == kind && xferWord == ctrl, req,
        {24'h0, xferKind, xferChan, xferTc, xferWord}, {24'h0, kind, 2'(chan), tc, ctrl});
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(xferValid == 1'b0, "R1", 32'(xferValid), 0);
    for (int i = 0; i < 16; i++) readChk(i, "R1");
  endtask

  task automatic tRegs();
    for (int i = 0; i < 16; i++) doWrite(i, 8'(8'h10 + i * 8'h0b));
    for (int i = 0; i < 16; i++) readChk(i, "R2");
  endtask

  task automatic tMap0();
    for (int c = 0; c < 4; c++) doAck(1'b0, c, 2'd0, 16'h1234 + 16'(c), 1'b0, "R3 R5");
    doAck(1'b0, 2, 2'd1, 16'hfedc, 1'b1, "R5");
  endtask

  task automatic tMap1();
    for (int c = 0; c < 4; c++) doAck(1'b1, c, 2'd1, 16'h0abc + 16'(c), 1'b0, "R4 R6");
  endtask

  task automatic tCarry();
    doWrite(15, 8'h42);
    doAck(1'b1, 0, 2'd0, 16'h8001, 1'b1, "R6");
    chk(xferAddr == 24'h430002, "R6", 32'(xferAddr), 32'h430002);
  endtask

  task automatic tVerify();
    doAck(1'b0, 1, 2'd2, 16'hffff, 1'b1, "R7");
    doAck(1'b1, 3, 2'd3, 16'h5555, 1'b0, "R7");
  endtask

  task automatic tPulse();
    doAck(1'b0, 0, 2'd0, 16'h0001, 1'b0, "R8");
    @(negedge clk);
    chk(xferValid == 1'b0, "R8", 32'(xferValid), 0);
  endtask

  task automatic tCollide();
    logic [23:0] e;
    e = expAddr(1'b0, 0, 16'h0100);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = 4'd7; regWrData = 8'hee;
    ackValid = 1'b1; ackCtrl = 1'b0; ackChan = 2'd0; ackKind = 2'd0;
    ackOffset = 16'h0100; ackTc = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0; ackValid = 1'b0;
    model[7] = 8'hee;
    chk(xferAddr == e, "R9", 32'(xferAddr), 32'(e));
    readChk(7, "R9");
    doAck(1'b0, 0, 2'd0, 16'h0100, 1'b0, "R9");
  endtask

  task automatic tUnmapped();
    int un[8] = '{0, 4, 5, 6, 8, 12, 13, 14};
    for (int i = 0; i < 8; i++) doWrite(un[i], 8'hc0 + 8'(i));
    for (int i = 0; i < 8; i++) readChk(un[i], "R10");
    for (int c = 0; c < 4; c++) begin
      doAck(1'b0, c, 2'd0, 16'h2222, 1'b0, "R10");
      doAck(1'b1, c, 2'd1, 16'h3333, 1'b0, "R10");
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRegs();
    tMap0();
    tMap1();
    tCarry();
    tVerify();
    tPulse();
    tCollide();
    tUnmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule